// File: doc/BRIEF.md
# Set-Associative Translation Cache With Walker Refill

This block keeps a small number of recent virtual-to-physical page translations so that most lookups need no page table walk. A lookup presents a virtual page number and a page offset. The page number is split into a set index (its low bits) and a tag (its high bits). All ways of the selected set are compared in parallel. On a hit the stored physical page number comes back in the same cycle, together with the full physical address, which is that page number joined to the unchanged offset.

When a valid lookup misses and no walk is in progress, the block raises a request to an external page table walker and records the missing page number. When the walker answers, a good result is written into the recorded set. A faulting result is passed back to the requester and is not kept. A flush input drops every cached translation at once, which is meant for context switches. It also abandons any walk in progress.

With the default parameters there are 16 entries in 4 sets of 4 ways, an 8-bit page number, a 6-bit physical page number and a 6-bit page offset.

Top module: `tlbTop`

## Requirements
- R1: After reset no entry is valid: every lookup misses, and with `lookupValid` low `missReq` is low.
- R2: A lookup hits in the same cycle when `lookupValid` is high and a valid way of set `lookupVpn[1:0]` holds tag `lookupVpn[7:2]`. On a hit `lookupPpn` is the stored page number and `physAddr` equals `{lookupPpn, lookupOffset}`. With `lookupValid` low, `hit` is low.
- R3: A valid lookup that misses while no walk is pending raises `missReq` in the same cycle, with `missVpn` equal to `lookupVpn`. While a walk is pending, `missReq` stays low.
- R4: A `walkDone` pulse with `walkFault` low, given while a walk is pending, installs `walkPpn` for the pending page number. A lookup of that page number hits from the next cycle on.
- R5: A refill writes the lowest-numbered invalid way of its set.
- R6: A refill into a set whose ways are all valid replaces the way chosen by that set's own round-robin pointer. The pointer is 0 after reset, advances by one (wrapping) only on such a replacement, and is not changed by flush.
- R7: A `walkDone` with `walkFault` high, given while a walk is pending, raises `faultOut` in that cycle and installs nothing. The page number still misses afterwards.
- R8: `flush` invalidates every entry in one cycle, so that nothing hits in the following cycle. It also cancels a pending walk: a walk result given in the same cycle as the flush, or later, is not installed.
- R9: A page number is never held in two ways of a set. At most one way matches any lookup, and a cached page number raises no further walk request. If several ways did match, the lowest-numbered way would be used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVpn | input | 8 | Virtual page number to translate |
| lookupOffset | input | 6 | Page offset, passed through unchanged |
| hit | output | 1 | Translation found this cycle |
| lookupPpn | output | 6 | Physical page number on a hit, zero otherwise |
| physAddr | output | 12 | Physical page number joined to the page offset |
| missReq | output | 1 | Request to the walker |
| missVpn | output | 8 | Page number that the walker is asked to translate |
| walkDone | input | 1 | Walker result valid |
| walkFault | input | 1 | Walker reports that no translation exists |
| walkPpn | input | 6 | Physical page number from the walker |
| faultOut | output | 1 | Faulting walk reported back to the requester |
| flush | input | 1 | Invalidate all entries and cancel a pending walk |

## Verification
Hits are tried with page numbers spread over all four sets and with several offsets. Lookups that share a set but differ in tag, or share a tag but differ in set, must miss; this separates the index bits from the tag bits. Replacement is exercised by overfilling one set, flushing it, refilling it and overfilling it again. The victim that is lost shows whether the first-invalid rule, the per-set pointer and its persistence across flush are honoured, and a second set overfilled afterwards shows that the pointers are independent. Faulting walks, flushes that arrive during a walk or together with its result, and lookups with `lookupValid` low each show that nothing was installed or requested where it should not be.

// File: rtl/tlbPkg.sv
package tlbPkg;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_WAIT = 1'b1
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic install;
    logic clearAll;
  } dpStrobe_t;

endpackage

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlbPkg::*;
#(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  output logic             hitAny,
  output logic [PPN_W-1:0] hitPpn,
  output logic [WAYS-1:0]  matchVec
);

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

  logic [WAYS-1:0]  validQ [SETS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [PPN_W-1:0] ppnQ   [SETS][WAYS];
  logic [WAY_W-1:0] rrQ    [SETS];

  logic [IDX_W-1:0] lookSet;
  logic [TAG_W-1:0] lookTag;
  logic [IDX_W-1:0] fillSet;
  logic [TAG_W-1:0] fillTag;
  logic [WAY_W-1:0] victimWay;
  logic             setFull;

  assign lookSet = lookupVpn[IDX_W-1:0];
  assign lookTag = lookupVpn[VPN_W-1:IDX_W];
  assign fillSet = fillVpn[IDX_W-1:0];
  assign fillTag = fillVpn[VPN_W-1:IDX_W];

  // parallel tag compare, one comparator per way
  generate
    for (genvar w = 0; w < WAYS; w++) begin : gCompare
      assign matchVec[w] = validQ[lookSet][w] && (tagQ[lookSet][w] == lookTag);
    end
  endgenerate

  // lowest-numbered matching way drives the result
  always_comb begin
    hitAny = |matchVec;
    hitPpn = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) hitPpn = ppnQ[lookSet][w];
    end
  end

  // victim: first invalid way, else the set's round-robin pointer
  always_comb begin
    setFull   = &validQ[fillSet];
    victimWay = rrQ[fillSet];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!validQ[fillSet][w]) victimWay = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        rrQ[s]    <= '0;
      end
    end else if (strobe.clearAll) begin
      for (int s = 0; s < SETS; s++) validQ[s] <= '0;
    end else if (strobe.install) begin
      validQ[fillSet][victimWay] <= 1'b1;
      if (setFull) begin
        rrQ[fillSet] <= (rrQ[fillSet] == LAST_WAY) ? '0 : rrQ[fillSet] + 1'b1;
      end
    end
  end

  // entry payload carries no reset; validQ qualifies it
  always_ff @(posedge clk) begin
    if (strobe.install && !strobe.clearAll) begin
      tagQ[fillSet][victimWay] <= fillTag;
      ppnQ[fillSet][victimWay] <= fillPpn;
    end
  end

endmodule

// File: rtl/tlbControl.sv
module tlbControl
  import tlbPkg::*;
#(
  parameter int VPN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic             hitAny,
  input  logic             flush,
  input  logic             walkDone,
  input  logic             walkFault,
  output logic             missReq,
  output logic [VPN_W-1:0] missVpn,
  output logic             faultOut,
  output logic [VPN_W-1:0] fillVpn,
  output dpStrobe_t        strobe
);

  ctlState_t        stateQ;
  logic [VPN_W-1:0] pendVpnQ;
  logic             waiting;
  logic             walkBack;

  assign waiting  = (stateQ == CTL_WAIT);
  assign walkBack = waiting && walkDone && !flush;

  assign missReq  = !waiting && lookupValid && !hitAny;
  assign missVpn  = lookupVpn;
  assign faultOut = walkBack && walkFault;
  assign fillVpn  = pendVpnQ;

  always_comb begin
    strobe          = '0;
    strobe.clearAll = flush;
    strobe.install  = walkBack && !walkFault;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= CTL_IDLE;
      pendVpnQ <= '0;
    end else begin
      unique case (stateQ)
        CTL_IDLE: begin
          if (missReq && !flush) begin
            stateQ   <= CTL_WAIT;
            pendVpnQ <= lookupVpn;
          end
        end
        CTL_WAIT: begin
          if (flush || walkDone) stateQ <= CTL_IDLE;
        end
        default: stateQ <= CTL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tlbTop.sv
module tlbTop
  import tlbPkg::*;
#(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int OFF_W = 6,
  parameter int SETS  = 4,
  parameter int WAYS  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [VPN_W-1:0]       lookupVpn,
  input  logic [OFF_W-1:0]       lookupOffset,
  output logic                   hit,
  output logic [PPN_W-1:0]       lookupPpn,
  output logic [PPN_W+OFF_W-1:0] physAddr,
  output logic                   missReq,
  output logic [VPN_W-1:0]       missVpn,
  input  logic                   walkDone,
  input  logic                   walkFault,
  input  logic [PPN_W-1:0]       walkPpn,
  output logic                   faultOut,
  input  logic                   flush
);

  dpStrobe_t        strobe;
  logic             hitAny;
  logic [PPN_W-1:0] hitPpn;
  logic [WAYS-1:0]  matchVec;
  logic [VPN_W-1:0] fillVpn;

  tlbControl #(.VPN_W(VPN_W)) uControl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .lookupVpn   (lookupVpn),
    .hitAny      (hitAny),
    .flush       (flush),
    .walkDone    (walkDone),
    .walkFault   (walkFault),
    .missReq     (missReq),
    .missVpn     (missVpn),
    .faultOut    (faultOut),
    .fillVpn     (fillVpn),
    .strobe      (strobe)
  );

  tlbDatapath #(
    .VPN_W (VPN_W),
    .PPN_W (PPN_W),
    .SETS  (SETS),
    .WAYS  (WAYS)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lookupVpn (lookupVpn),
    .fillVpn   (fillVpn),
    .fillPpn   (walkPpn),
    .hitAny    (hitAny),
    .hitPpn    (hitPpn),
    .matchVec  (matchVec)
  );

  assign hit       = lookupValid && hitAny;
  assign lookupPpn = hit ? hitPpn : '0;
  assign physAddr  = {lookupPpn, lookupOffset};

endmodule

// File: rtl/tlbChecker.sv
module tlbChecker #(
  parameter int PPN_W = 6,
  parameter int OFF_W = 6,
  parameter int WAYS  = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [OFF_W-1:0]       lookupOffset,
  input logic                   hit,
  input logic [PPN_W+OFF_W-1:0] physAddr,
  input logic                   missReq,
  input logic                   faultOut,
  input logic                   flush,
  input logic [WAYS-1:0]        matchVec
);

  // R9: a tag is never present twice in one set
  assert_single_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(matchVec) <= 1);

  // R2: the page offset is carried through untouched on a hit
  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> physAddr[OFF_W-1:0] == lookupOffset);

  // R8: after a flush nothing hits
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hit);

  // R3: one walk outstanding at a time
  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rstN)
    (missReq && !flush) |=> !missReq);

  // R7: a fault return only comes back while a walk is pending
  assert_fault_when_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |-> !missReq);

endmodule

bind tlbTop tlbChecker #(
  .PPN_W (PPN_W),
  .OFF_W (OFF_W),
  .WAYS  (WAYS)
) uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .lookupOffset (lookupOffset),
  .hit          (hit),
  .physAddr     (physAddr),
  .missReq      (missReq),
  .faultOut     (faultOut),
  .flush        (flush),
  .matchVec     (matchVec)
);

// File: tb/tb_tlbTop.sv
module tb_tlbTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [7:0]  lookupVpn = '0;
  logic [5:0]  lookupOffset = '0;
  logic        hit;
  logic [5:0]  lookupPpn;
  logic [11:0] physAddr;
  logic        missReq;
  logic [7:0]  missVpn;
  logic        walkDone = 1'b0;
  logic        walkFault = 1'b0;
  logic [5:0]  walkPpn = '0;
  logic        faultOut;
  logic        flush = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tlbTop dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .lookupOffset(lookupOffset), .hit(hit), .lookupPpn(lookupPpn),
    .physAddr(physAddr), .missReq(missReq), .missVpn(missVpn),
    .walkDone(walkDone), .walkFault(walkFault), .walkPpn(walkPpn),
    .faultOut(faultOut), .flush(flush)
  );

  function automatic logic [5:0] ppnOf(input logic [7:0] vpn);
    return 6'(vpn * 5 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expectHit(input string req, input logic [7:0] vpn,
                           input logic [5:0] off);
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = vpn; lookupOffset = off;
    #1;
    chk(hit == 1'b1, req, "hit", int'(hit), 1);
    chk(lookupPpn == ppnOf(vpn), req, "ppn", int'(lookupPpn), int'(ppnOf(vpn)));
    chk(physAddr == {ppnOf(vpn), off}, req, "physAddr", int'(physAddr),
        int'({ppnOf(vpn), off}));
    chk(missReq == 1'b0, req, "missReq on hit", int'(missReq), 0);
    lookupValid = 1'b0;
  endtask

  task automatic expectMiss(input string req, input logic [7:0] vpn);
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = vpn; lookupOffset = 6'h2B;
    #1;
    chk(hit == 1'b0, req, "hit on miss", int'(hit), 0);
    chk(missReq == 1'b1, req, "missReq", int'(missReq), 1);
    chk(missVpn == vpn, req, "missVpn", int'(missVpn), int'(vpn));
    lookupValid = 1'b0;
  endtask

  // miss, walk, return; checks R3 and R7 along the way
  task automatic refill(input logic [7:0] vpn, input bit fault);
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = vpn;
    #1;
    chk(missReq == 1'b1 && missVpn == vpn, "R3", "request raised",
        int'(missReq), 1);
    @(negedge clk);
    #1;
    chk(missReq == 1'b0, "R3", "no request while pending", int'(missReq), 0);
    lookupValid = 1'b0;
    walkDone = 1'b1; walkFault = fault; walkPpn = ppnOf(vpn);
    #1;
    chk(faultOut == fault, "R7", "faultOut", int'(faultOut), int'(fault));
    @(negedge clk);
    walkDone = 1'b0; walkFault = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    chk(hit == 1'b0 && missReq == 1'b0, "R1", "idle outputs", int'({hit, missReq}), 0);
    expectMiss("R1", 8'h00);
    expectMiss("R1", 8'hFF);
  endtask

  task automatic testHits();
    refill(8'h0F, 1'b0);
    refill(8'h3C, 1'b0);
    refill(8'hA1, 1'b0);
    refill(8'hFE, 1'b0);
    expectHit("R4", 8'h0F, 6'h00);
    expectHit("R2", 8'h3C, 6'h3F);
    expectHit("R2", 8'hA1, 6'h15);
    expectHit("R2", 8'hFE, 6'h2A);
    expectMiss("R2", 8'h13);   // same set as 0F, other tag
    expectMiss("R2", 8'h0C);   // same tag as 0F, other set
    @(negedge clk);
    lookupValid = 1'b0; lookupVpn = 8'h0F;
    #1;
    chk(hit == 1'b0 && missReq == 1'b0, "R2", "lookupValid low",
        int'({hit, missReq}), 0);
    // R9: a cached page raises no second walk
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      lookupValid = 1'b1; lookupVpn = 8'hA1;
      #1;
      chk(missReq == 1'b0 && hit == 1'b1, "R9", "repeat lookup", int'(missReq), 0);
    end
    lookupValid = 1'b0;
  endtask

  task automatic testFault();
    refill(8'h55, 1'b1);
    expectMiss("R7", 8'h55);
  endtask

  task automatic testFlush();
    doFlush();
    expectMiss("R8", 8'h0F);
    expectMiss("R8", 8'hFE);
    // flush while a walk is pending, result arrives later
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = 8'h77;
    @(negedge clk);
    lookupValid = 1'b0; flush = 1'b1;
    @(negedge clk);
    flush = 1'b0; walkDone = 1'b1; walkPpn = ppnOf(8'h77);
    @(negedge clk);
    walkDone = 1'b0;
    expectMiss("R8", 8'h77);
    // flush in the same cycle as the walk result
    @(negedge clk);
    lookupValid = 1'b1; lookupVpn = 8'h66;
    @(negedge clk);
    lookupValid = 1'b0; flush = 1'b1; walkDone = 1'b1; walkPpn = ppnOf(8'h66);
    @(negedge clk);
    flush = 1'b0; walkDone = 1'b0;
    expectMiss("R8", 8'h66);
  endtask

  task automatic testReplace();
    doFlush();
    refill(8'h01, 1'b0);
    refill(8'h05, 1'b0);
    refill(8'h09, 1'b0);
    refill(8'h0D, 1'b0);
    refill(8'h11, 1'b0);   // replaces way 0 (01), pointer to 1
    expectMiss("R6", 8'h01);
    expectHit("R6", 8'h05, 6'h01);
    expectHit("R6", 8'h11, 6'h02);
    refill(8'h15, 1'b0);   // replaces way 1 (05), pointer to 2
    expectMiss("R6", 8'h05);
    expectHit("R6", 8'h09, 6'h03);
    // set 2 keeps its own pointer at 0
    refill(8'h02, 1'b0);
    refill(8'h06, 1'b0);
    refill(8'h0A, 1'b0);
    refill(8'h0E, 1'b0);
    refill(8'h12, 1'b0);
    expectMiss("R6", 8'h02);
    expectHit("R6", 8'h0A, 6'h04);
    // after flush, invalid ways fill from way 0 regardless of pointer
    doFlush();
    refill(8'h21, 1'b0);
    refill(8'h25, 1'b0);
    refill(8'h29, 1'b0);
    refill(8'h2D, 1'b0);
    expectHit("R5", 8'h21, 6'h05);
    expectHit("R5", 8'h2D, 6'h06);
    refill(8'h31, 1'b0);   // pointer kept at 2: replaces 29
    expectMiss("R6", 8'h29);
    expectHit("R5", 8'h21, 6'h07);
    expectHit("R5", 8'h25, 6'h08);
    expectHit("R6", 8'h2D, 6'h09);
    expectHit("R6", 8'h31, 6'h0A);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testHits();
    testFault();
    testFlush();
    testReplace();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule